// File: doc/BRIEF.md
# Dual-Port DDR Pixel Output Formatter

This block turns a stream of 24-bit pixels into data for two 12-bit display output ports, named B and C. Both ports move data on both edges of their clock. Each output cycle is therefore shown as four registered 12-bit words: a rising-edge word and a falling-edge word for port B, and the same pair for port C. A single output-valid flag marks the cycles that carry data. Every pixel is made of a high 12-bit half and a low 12-bit half.

There are three lane mappings:

- **Single-channel.** Port B sends one pixel per clock, one half on each edge. Port C stays at zero.
- **High-low split.** Each edge carries a whole pixel, with its two halves placed on the two ports. A swap bit chooses which port gets which half.
- **Odd-even interleave.** Port B sends the even pixel and port C sends the odd pixel of each pair. Each port sends both halves of its pixel across the two edges.

Pixels enter through a valid/ready handshake. The first pixel of each line carries a line-start flag. The mode, order and swap controls take effect only when a line starts. In the two dual modes, pixels are collected in pairs. A line that ends on an unpaired pixel is padded with zero, and a sticky error flag is raised.

Top module: `pixel_ddr_formatter`

## Requirements
- R1: When reset is asserted, out_valid, all four output words and err_odd_line are 0, and in_ready is 1.
- R2: Mode code 0 is single-channel. Each pixel accepted yields one output cycle in the following clock. With order bit 0, b_rise carries the low half (bits 11:0) and b_fall carries the high half (bits 23:12). With order bit 1, the two halves are exchanged.
- R3: Mode code 3 behaves exactly like code 0. In either single mode, c_rise and c_fall are 0 in every valid output cycle.
- R4: Mode code 1 is the high-low split. The first pixel of a pair goes on the rising edge and the second on the falling edge. With swap 0, port B carries the low half and port C carries the high half. With swap 1, port B carries the high half and port C carries the low half. The order bit has no effect in this mode.
- R5: Mode code 2 is the odd-even interleave. Port B carries the even pixel and port C carries the odd pixel. On each port, the half sent on the rising edge is the low half when the order bit is 0 and the high half when the order bit is 1.
- R6: In dual modes, the pixel that carries the line-start flag is pixel zero and counts as even. Output becomes valid only in the clock after the second pixel of a pair is accepted, however many idle cycles separate the two pixels.
- R7: cfg_mode, cfg_order and cfg_swap are captured only together with an accepted line-start pixel. Changing them in the middle of a line leaves that line's mapping unchanged.
- R8: A line-start pixel may arrive while a dual-mode pixel is still waiting for its partner. In that cycle in_ready is 0. In the next clock, the waiting pixel is sent as the even pixel with a zero partner, using the previous line's settings. err_odd_line then rises and stays 1 until reset.
- R9: In every clock without an output cycle, out_valid is 0 and all four output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Lane mapping: 0/3 single, 1 high-low, 2 odd-even |
| cfg_order | input | 1 | Half order: 0 low first, 1 high first |
| cfg_swap | input | 1 | High-low port swap: 0 B low/C high, 1 B high/C low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_pix | input | 24 | Pixel, high half in bits 23:12 |
| out_valid | output | 1 | Output words hold one clock of port data |
| b_rise | output | 12 | Port B rising-edge word |
| b_fall | output | 12 | Port B falling-edge word |
| c_rise | output | 12 | Port C rising-edge word |
| c_fall | output | 12 | Port C falling-edge word |
| err_odd_line | output | 1 | Sticky flag for a dual-mode line with an odd pixel count |

## Verification
Each mode is driven with lines of distinct pixel values, under both settings of the order bit and of the swap bit. This separates the two halves of a pixel and the two pixels of a pair, so a swapped edge, a swapped port or a swapped pixel all show up as wrong data. Idle cycles are placed between the two pixels of a pair, and between lines, to check that output waits for a full pair. Mid-line control changes check that settings are captured only at line start. An odd-length odd-even line, followed by a new line, checks the stall, the zero pad and the sticky error flag.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    localparam int HALF_W = 12;
    localparam int PIX_W  = 2 * HALF_W;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_HILO     = 2'd1,
        MODE_ODDEVEN  = 2'd2,
        MODE_SINGLE_B = 2'd3
    } mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } pixel_t;

    typedef struct packed {
        mode_e mode;
        logic  order;
        logic  swap;
    } cfg_t;

    typedef struct packed {
        logic [HALF_W-1:0] b_rise;
        logic [HALF_W-1:0] b_fall;
        logic [HALF_W-1:0] c_rise;
        logic [HALF_W-1:0] c_fall;
    } lanes_t;

    localparam cfg_t CFG_RESET = '{mode: MODE_SINGLE, order: 1'b0, swap: 1'b0};

    function automatic logic is_dual(input mode_e m);
        return (m == MODE_HILO) || (m == MODE_ODDEVEN);
    endfunction

    function automatic logic [HALF_W-1:0] first_half(input pixel_t p, input logic order);
        return order ? p.hi : p.lo;
    endfunction

    function automatic logic [HALF_W-1:0] second_half(input pixel_t p, input logic order);
        return order ? p.lo : p.hi;
    endfunction

endpackage

// File: rtl/pdf_line_ctl.sv
module pdf_line_ctl
    import pdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_sol,
    input  pixel_t in_pix,
    input  cfg_t   live_cfg,
    output logic   in_ready,
    output logic   emit,
    output cfg_t   emit_cfg,
    output pixel_t emit_p0,
    output pixel_t emit_p1,
    output logic   err_odd
);

    cfg_t   line_cfg;
    cfg_t   eff_cfg;
    logic   pend;
    pixel_t pend_pix;
    logic   flush;
    logic   acc;

    always_comb begin
        flush    = pend && in_valid && in_sol;
        in_ready = !flush;
        acc      = in_valid && !flush;
        eff_cfg  = in_sol ? live_cfg : line_cfg;
        emit     = flush || (acc && (!is_dual(eff_cfg.mode) || pend));
        emit_cfg = flush ? line_cfg : eff_cfg;
        emit_p0  = (flush || pend) ? pend_pix : in_pix;
        emit_p1  = flush ? pixel_t'('0) : in_pix;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cfg <= CFG_RESET;
            pend     <= 1'b0;
            pend_pix <= '0;
            err_odd  <= 1'b0;
        end else if (flush) begin
            pend    <= 1'b0;
            err_odd <= 1'b1;
        end else if (acc) begin
            if (in_sol) line_cfg <= live_cfg;
            if (is_dual(eff_cfg.mode)) begin
                if (!pend) begin
                    pend     <= 1'b1;
                    pend_pix <= in_pix;
                end else begin
                    pend <= 1'b0;
                end
            end
        end
    end

    // R8: once raised, the odd-line flag holds until reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_odd |=> err_odd);

    // R8: a padded flush clears the waiting pixel and raises the flag
    p_flush_err_r8: assert property (@(posedge clk) disable iff (rst)
        (pend && in_valid && in_sol) |=> (err_odd && !pend));

    // R6: a line-start pixel in a dual mode is held as the even pixel
    p_first_even_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && in_sol && is_dual(live_cfg.mode)) |=> (pend && pend_pix == $past(in_pix)));

endmodule

// File: rtl/pdf_lane_map.sv
module pdf_lane_map
    import pdf_pkg::*;
(
    input  cfg_t   cfg,
    input  pixel_t p0,
    input  pixel_t p1,
    output lanes_t lanes
);

    always_comb begin
        lanes = '0;
        unique case (cfg.mode)
            MODE_HILO: begin
                lanes.b_rise = cfg.swap ? p0.hi : p0.lo;
                lanes.c_rise = cfg.swap ? p0.lo : p0.hi;
                lanes.b_fall = cfg.swap ? p1.hi : p1.lo;
                lanes.c_fall = cfg.swap ? p1.lo : p1.hi;
            end
            MODE_ODDEVEN: begin
                lanes.b_rise = first_half(p0, cfg.order);
                lanes.b_fall = second_half(p0, cfg.order);
                lanes.c_rise = first_half(p1, cfg.order);
                lanes.c_fall = second_half(p1, cfg.order);
            end
            default: begin
                lanes.b_rise = first_half(p0, cfg.order);
                lanes.b_fall = second_half(p0, cfg.order);
            end
        endcase
    end

endmodule

// File: rtl/pdf_out_stage.sv
module pdf_out_stage
    import pdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   emit,
    input  lanes_t lanes_d,
    output logic   valid_q,
    output lanes_t lanes_q
);

    always_ff @(posedge clk) begin
        if (rst || !emit) begin
            valid_q <= 1'b0;
            lanes_q <= '0;
        end else begin
            valid_q <= 1'b1;
            lanes_q <= lanes_d;
        end
    end

endmodule

// File: rtl/pixel_ddr_formatter.sv
module pixel_ddr_formatter
    import pdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_order,
    input  logic              cfg_swap,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [HALF_W-1:0] b_rise,
    output logic [HALF_W-1:0] b_fall,
    output logic [HALF_W-1:0] c_rise,
    output logic [HALF_W-1:0] c_fall,
    output logic              err_odd_line
);

    cfg_t   live_cfg;
    logic   emit;
    cfg_t   emit_cfg;
    pixel_t emit_p0;
    pixel_t emit_p1;
    lanes_t lanes_d;
    lanes_t lanes_q;

    assign live_cfg = '{mode: mode_e'(cfg_mode), order: cfg_order, swap: cfg_swap};

    pdf_line_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_pix   (pixel_t'(in_pix)),
        .live_cfg (live_cfg),
        .in_ready (in_ready),
        .emit     (emit),
        .emit_cfg (emit_cfg),
        .emit_p0  (emit_p0),
        .emit_p1  (emit_p1),
        .err_odd  (err_odd_line)
    );

    pdf_lane_map u_map (
        .cfg   (emit_cfg),
        .p0    (emit_p0),
        .p1    (emit_p1),
        .lanes (lanes_d)
    );

    pdf_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .emit    (emit),
        .lanes_d (lanes_d),
        .valid_q (out_valid),
        .lanes_q (lanes_q)
    );

    assign b_rise = lanes_q.b_rise;
    assign b_fall = lanes_q.b_fall;
    assign c_rise = lanes_q.c_rise;
    assign c_fall = lanes_q.c_fall;

    // R9: a clock without an emitted pair leaves the ports idle and zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !emit |=> (!out_valid && b_rise == '0 && b_fall == '0 && c_rise == '0 && c_fall == '0));

    // R3: single-channel output never drives port C
    p_single_c_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (emit && !is_dual(emit_cfg.mode)) |=> (out_valid && c_rise == '0 && c_fall == '0));

    // R6: output appears exactly one clock after an emit decision
    p_emit_valid_r6: assert property (@(posedge clk) disable iff (rst)
        emit |=> out_valid);

endmodule

// File: tb/pixel_ddr_formatter_test.sv
`timescale 1ns/1ps
module pixel_ddr_formatter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_mode;
    logic        cfg_order;
    logic        cfg_swap;
    logic        in_valid;
    logic        in_ready;
    logic        in_sol;
    logic [23:0] in_pix;
    logic        out_valid;
    logic [11:0] b_rise, b_fall, c_rise, c_fall;
    logic        err_odd_line;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference state
    bit          m_held_f;
    logic [23:0] m_held;
    int          m_mode;
    bit          m_ord, m_swp, m_err;
    bit          e_valid;
    logic [11:0] e_br, e_bf, e_cr, e_cf;
    int          pix_no = 0;

    always #2.5 clk = ~clk;

    pixel_ddr_formatter uut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_order(cfg_order),
        .cfg_swap(cfg_swap), .in_valid(in_valid), .in_ready(in_ready),
        .in_sol(in_sol), .in_pix(in_pix), .out_valid(out_valid),
        .b_rise(b_rise), .b_fall(b_fall), .c_rise(c_rise), .c_fall(c_fall),
        .err_odd_line(err_odd_line)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (R1..R9 run incomplete) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    function automatic logic [23:0] next_pix();
        pix_no++;
        return (pix_no * 24'h13579B + 24'h0A0B0C) & 24'hFFFFFF;
    endfunction

    task automatic model_emit(input logic [23:0] p0, input logic [23:0] p1);
        e_valid = 1'b1;
        e_br = '0; e_bf = '0; e_cr = '0; e_cf = '0;
        if (m_mode == 1) begin
            if (m_swp) begin
                e_br = p0[23:12]; e_cr = p0[11:0]; e_bf = p1[23:12]; e_cf = p1[11:0];
            end else begin
                e_br = p0[11:0]; e_cr = p0[23:12]; e_bf = p1[11:0]; e_cf = p1[23:12];
            end
        end else if (m_mode == 2) begin
            e_br = m_ord ? p0[23:12] : p0[11:0];
            e_bf = m_ord ? p0[11:0]  : p0[23:12];
            e_cr = m_ord ? p1[23:12] : p1[11:0];
            e_cf = m_ord ? p1[11:0]  : p1[23:12];
        end else begin
            e_br = m_ord ? p0[23:12] : p0[11:0];
            e_bf = m_ord ? p0[11:0]  : p0[23:12];
        end
    endtask

    task automatic check_outputs(input string tag);
        tests++;
        if (out_valid !== e_valid || b_rise !== e_br || b_fall !== e_bf ||
            c_rise !== e_cr || c_fall !== e_cf || err_odd_line !== m_err) begin
            fails++;
            $display("FAIL %s outputs actual v=%0b b=%h/%h c=%h/%h err=%0b expected v=%0b b=%h/%h c=%h/%h err=%0b",
                     tag, out_valid, b_rise, b_fall, c_rise, c_fall, err_odd_line,
                     e_valid, e_br, e_bf, e_cr, e_cf, m_err);
        end
    endtask

    // one clock: check last result, drive inputs, predict next result
    task automatic cyc(input string tag, input bit v, input bit sol, input logic [23:0] pix,
                       input int mode, input bit ord, input bit swp);
        bit exp_rdy;
        @(negedge clk);
        check_outputs(tag);
        in_valid  = v;
        in_sol    = sol;
        in_pix    = pix;
        cfg_mode  = mode[1:0];
        cfg_order = ord;
        cfg_swap  = swp;
        #1;
        exp_rdy = !(v && sol && m_held_f);
        tests++;
        if (in_ready !== exp_rdy) begin
            fails++;
            $display("FAIL %s in_ready actual=%0b expected=%0b", tag, in_ready, exp_rdy);
        end
        e_valid = 1'b0;
        e_br = '0; e_bf = '0; e_cr = '0; e_cf = '0;
        if (v) begin
            if (m_held_f && sol) begin
                model_emit(m_held, 24'h0);
                m_err    = 1'b1;
                m_held_f = 1'b0;
            end else begin
                if (sol) begin
                    m_mode = mode; m_ord = ord; m_swp = swp;
                end
                if (m_mode == 1 || m_mode == 2) begin
                    if (!m_held_f) begin
                        m_held   = pix;
                        m_held_f = 1'b1;
                    end else begin
                        model_emit(m_held, pix);
                        m_held_f = 1'b0;
                    end
                end else begin
                    model_emit(pix, 24'h0);
                end
            end
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 24'h0, 0, 1'b0, 1'b0);
    endtask

    task automatic line(input string tag, input int n, input int mode, input bit ord, input bit swp);
        for (int i = 0; i < n; i++) cyc(tag, 1'b1, (i == 0), next_pix(), mode, ord, swp);
    endtask

    initial begin
        logic [23:0] px;
        rst = 1'b1; in_valid = 0; in_sol = 0; in_pix = '0;
        cfg_mode = 0; cfg_order = 0; cfg_swap = 0;
        m_held_f = 0; m_held = '0; m_mode = 0; m_ord = 0; m_swp = 0; m_err = 0;
        e_valid = 0; e_br = '0; e_bf = '0; e_cr = '0; e_cf = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outputs("R1");
        tests++;
        if (in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 in_ready actual=%0b expected=1", in_ready);
        end
        rst = 1'b0;
        idle("R1", 2);

        // R2: single-channel, both half orders
        line("R2", 4, 0, 1'b0, 1'b0);
        idle("R9", 2);
        line("R2", 3, 0, 1'b1, 1'b0);
        // R3: mode code 3 is single, port C silent
        line("R3", 3, 3, 1'b1, 1'b1);
        idle("R9", 1);

        // R4: high-low split, both swap settings, order bit ignored
        line("R4", 4, 1, 1'b0, 1'b0);
        line("R4", 4, 1, 1'b1, 1'b1);

        // R6: idle gap between the two pixels of a pair
        cyc("R6", 1'b1, 1'b1, next_pix(), 1, 1'b0, 1'b1);
        idle("R6", 3);
        cyc("R6", 1'b1, 1'b0, next_pix(), 1, 1'b0, 1'b1);
        idle("R6", 1);

        // R5: odd-even interleave, both orders
        line("R5", 4, 2, 1'b0, 1'b0);
        line("R5", 6, 2, 1'b1, 1'b0);

        // R7: mid-line control changes take no effect
        cyc("R7", 1'b1, 1'b1, next_pix(), 1, 1'b0, 1'b0);
        cyc("R7", 1'b1, 1'b0, next_pix(), 2, 1'b1, 1'b1);
        cyc("R7", 1'b1, 1'b0, next_pix(), 0, 1'b1, 1'b1);
        cyc("R7", 1'b1, 1'b0, next_pix(), 2, 1'b0, 1'b1);
        idle("R7", 1);

        // R8: odd-length dual line, then a new line stalls, pads and flags
        line("R8", 3, 2, 1'b1, 1'b0);
        px = next_pix();
        cyc("R8", 1'b1, 1'b1, px, 0, 1'b0, 1'b0);
        cyc("R8", 1'b1, 1'b1, px, 0, 1'b0, 1'b0);
        line("R8", 2, 1, 1'b0, 1'b1);
        idle("R8", 3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule